// File: doc/BRIEF.md
# Fixed-Function Event Counter Unit

This block holds a small bank of dedicated event counters, three by default, each 48 bits wide. Every counter watches its own event input. It advances by one on a clock cycle only when three things hold at once: the event is present, the counter's bit in a global enable mask is set, and the counter's two-bit ring code matches the current privilege input. A counter that wraps from all-ones to zero sets a sticky overflow flag. If the counter's interrupt bit is set, the wrap also raises a one-cycle interrupt pulse.

Software reaches the unit through a flat register port. There are eight word addresses, each 64 bits wide. Writes take effect at the clock edge. Reads come back registered one cycle later. The port gives access to the packed control fields, the global enable mask, the overflow flags, a write-one-to-clear register for those flags, the counters themselves and a read-only capability word.

Top module: `fxc_unit`

## Requirements
- R1: When synchronous reset is high, all counters, the control fields, the global enable mask, the overflow flags, `irq` and `reg_rdata` go to zero.
- R2: The control register at address 1 packs one 4-bit field per counter, with counter i at bits 4i+3:4i. In each field, bits 1:0 are the ring code and bit 3 is the interrupt enable. Bit 2 of each field and every bit above the fields read as zero, whatever was written.
- R3: The ring code decides whether a counter may count. Code 0 never counts. Code 1 counts only while `priv_kernel` is 1. Code 2 counts only while `priv_kernel` is 0. Code 3 counts at either level.
- R4: Bit i of the global enable register at address 2 must be set for counter i to count. A single write sets or clears any combination of these bits.
- R5: A counter that is allowed to count increases by exactly one on each clock edge where its `event_in` bit is high. It holds its value on every edge where that bit is low.
- R6: Counter i sits at address 5+i. A write loads the low 48 bits of `reg_wdata`, and bits 63:48 read as zero. A write to a counter takes priority over an increment in the same cycle.
- R7: When an increment takes a counter from all-ones to zero, bit i of the overflow status register at address 3 is set. It stays set until it is cleared.
- R8: Writing a 1 to bit i of the clear register at address 4 clears overflow flag i, and writing 0 leaves the flag alone. Address 4 reads as zero. If a wrap and a clear hit the same flag in the same cycle, the flag ends up set.
- R9: `irq` is high for exactly the one cycle after the edge at which a counter whose interrupt bit is set wraps. A wrap on a counter whose interrupt bit is clear leaves `irq` low.
- R10: Address 0 reads the capability word: the counter count in bits 4:0 and the counter width in bits 12:5, which is 0x603 by default. Writes to it are ignored.
- R11: `reg_rdata` shows, after each rising edge, the value that the register at `reg_addr` held just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| event_in | input | 3 | One event input per counter |
| priv_kernel | input | 1 | 1 = privileged level, 0 = user level |
| irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The hardest case to reach from the ports is a wrap that lands on the same edge as a clear of that same overflow flag. The outcome depends on write priority and on the sticky update at the same instant. The stimulus gets there by loading a counter with all-ones through the register port. On the next cycle it drives that counter's event together with a clear write, so the wrap edge is known exactly. It also loads a counter while its event is high, which shows that the load wins over the increment. It steps through all four ring codes at both privilege levels.

// File: rtl/fxc_pkg.sv
package fxc_pkg;

  // Register word addresses
  localparam int A_CAP  = 0;
  localparam int A_CTL  = 1;
  localparam int A_GEN  = 2;
  localparam int A_STAT = 3;
  localparam int A_CLR  = 4;
  localparam int A_CNT0 = 5;

  typedef enum logic [1:0] {
    RING_OFF  = 2'd0,
    RING_KERN = 2'd1,
    RING_USER = 2'd2,
    RING_ANY  = 2'd3
  } ring_code_e;

  function automatic logic ring_match(input logic [1:0] code, input logic kern);
    case (ring_code_e'(code))
      RING_KERN: ring_match = kern;
      RING_USER: ring_match = !kern;
      RING_ANY:  ring_match = 1'b1;
      default:   ring_match = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fxc_counter.sv
module fxc_counter
  import fxc_pkg::*;
#(
  parameter int CTR_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ring_code,
  input  logic             glb_en,
  input  logic             evt,
  input  logic             priv_kernel,
  input  logic             ld,
  input  logic [CTR_W-1:0] ld_val,
  output logic [CTR_W-1:0] cnt,
  output logic             wrap
);

  logic inc;

  assign inc  = evt && glb_en && ring_match(ring_code, priv_kernel);
  // A load in the same cycle suppresses the increment and the wrap
  assign wrap = inc && !ld && (&cnt);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/fxc_ctl_regs.sv
module fxc_ctl_regs #(
  parameter int NUM_CTR = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_ctl,
  input  logic                   wr_gen,
  input  logic                   wr_clr,
  input  logic [4*NUM_CTR-1:0]   ctl_wdata,
  input  logic [NUM_CTR-1:0]     msk_wdata,
  input  logic [NUM_CTR-1:0]     wrap_vec,
  output logic [4*NUM_CTR-1:0]   ctl_q,
  output logic [NUM_CTR-1:0]     gen_q,
  output logic [NUM_CTR-1:0]     ovf_q,
  output logic [NUM_CTR-1:0]     pmi_vec,
  output logic [2*NUM_CTR-1:0]   ring_vec,
  output logic                   irq
);

  localparam int CTL_W = 4 * NUM_CTR;

  function automatic logic [CTL_W-1:0] field_mask();
    logic [CTL_W-1:0] m;
    for (int i = 0; i < NUM_CTR; i++) m[4*i +: 4] = 4'b1011;
    return m;
  endfunction

  localparam logic [CTL_W-1:0] FIELD_MASK = field_mask();

  logic [NUM_CTR-1:0] clr_vec;
  assign clr_vec = wr_clr ? msk_wdata : '0;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_fld
    assign pmi_vec[i]          = ctl_q[4*i+3];
    assign ring_vec[2*i +: 2]  = ctl_q[4*i +: 2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      gen_q <= '0;
      ovf_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= ctl_wdata & FIELD_MASK;
      if (wr_gen) gen_q <= msk_wdata;
      // A wrap in the same cycle wins over the clear
      ovf_q <= (ovf_q & ~clr_vec) | wrap_vec;
      irq   <= |(wrap_vec & pmi_vec);
    end
  end

endmodule

// File: rtl/fxc_read_mux.sv
module fxc_read_mux
  import fxc_pkg::*;
#(
  parameter int NUM_CTR = 3,
  parameter int CTR_W   = 48,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [4*NUM_CTR-1:0]     ctl_q,
  input  logic [NUM_CTR-1:0]       gen_q,
  input  logic [NUM_CTR-1:0]       ovf_q,
  input  logic [NUM_CTR*CTR_W-1:0] cnt_flat,
  output logic [DATA_W-1:0]        rdata
);

  localparam logic [ADDR_W-1:0] AD_CAP  = ADDR_W'(A_CAP);
  localparam logic [ADDR_W-1:0] AD_CTL  = ADDR_W'(A_CTL);
  localparam logic [ADDR_W-1:0] AD_GEN  = ADDR_W'(A_GEN);
  localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] AD_CNT0 = ADDR_W'(A_CNT0);

  localparam logic [DATA_W-1:0] CAP_WORD =
    (DATA_W'(CTR_W % 256) << 5) | DATA_W'(NUM_CTR % 32);

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (addr == AD_CAP)  rd_next = CAP_WORD;
    if (addr == AD_CTL)  rd_next[4*NUM_CTR-1:0] = ctl_q;
    if (addr == AD_GEN)  rd_next[NUM_CTR-1:0]   = gen_q;
    if (addr == AD_STAT) rd_next[NUM_CTR-1:0]   = ovf_q;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (addr == AD_CNT0 + ADDR_W'(i))
        rd_next[CTR_W-1:0] = cnt_flat[i*CTR_W +: CTR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

endmodule

// File: rtl/fxc_unit.sv
module fxc_unit
  import fxc_pkg::*;
#(
  parameter int NUM_CTR = 3,
  parameter int CTR_W   = 48,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_CTR-1:0] event_in,
  input  logic              priv_kernel,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] AD_CTL  = ADDR_W'(A_CTL);
  localparam logic [ADDR_W-1:0] AD_GEN  = ADDR_W'(A_GEN);
  localparam logic [ADDR_W-1:0] AD_CLR  = ADDR_W'(A_CLR);
  localparam logic [ADDR_W-1:0] AD_CNT0 = ADDR_W'(A_CNT0);

  logic [4*NUM_CTR-1:0]     ctl_q;
  logic [NUM_CTR-1:0]       gen_q;
  logic [NUM_CTR-1:0]       ovf_q;
  logic [NUM_CTR-1:0]       pmi_vec;
  logic [2*NUM_CTR-1:0]     ring_vec;
  logic [NUM_CTR-1:0]       wrap_vec;
  logic [NUM_CTR-1:0]       ld_vec;
  logic [NUM_CTR*CTR_W-1:0] cnt_flat;
  logic                     unused_wdata;

  assign unused_wdata = &{1'b0, reg_wdata[DATA_W-1:CTR_W]};

  fxc_ctl_regs #(.NUM_CTR(NUM_CTR)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_ctl    (reg_wr && reg_addr == AD_CTL),
    .wr_gen    (reg_wr && reg_addr == AD_GEN),
    .wr_clr    (reg_wr && reg_addr == AD_CLR),
    .ctl_wdata (reg_wdata[4*NUM_CTR-1:0]),
    .msk_wdata (reg_wdata[NUM_CTR-1:0]),
    .wrap_vec  (wrap_vec),
    .ctl_q     (ctl_q),
    .gen_q     (gen_q),
    .ovf_q     (ovf_q),
    .pmi_vec   (pmi_vec),
    .ring_vec  (ring_vec),
    .irq       (irq)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign ld_vec[i] = reg_wr && (reg_addr == AD_CNT0 + ADDR_W'(i));

    fxc_counter #(.CTR_W(CTR_W)) u_ctr (
      .clk         (clk),
      .rst         (rst),
      .ring_code   (ring_vec[2*i +: 2]),
      .glb_en      (gen_q[i]),
      .evt         (event_in[i]),
      .priv_kernel (priv_kernel),
      .ld          (ld_vec[i]),
      .ld_val      (reg_wdata[CTR_W-1:0]),
      .cnt         (cnt_flat[i*CTR_W +: CTR_W]),
      .wrap        (wrap_vec[i])
    );
  end

  fxc_read_mux #(
    .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_rmux (
    .clk      (clk),
    .rst      (rst),
    .addr     (reg_addr),
    .ctl_q    (ctl_q),
    .gen_q    (gen_q),
    .ovf_q    (ovf_q),
    .cnt_flat (cnt_flat),
    .rdata    (reg_rdata)
  );

endmodule

// File: rtl/fxc_unit_chk.sv
module fxc_unit_chk
  import fxc_pkg::*;
#(
  parameter int NUM_CTR = 3,
  parameter int CTR_W   = 48,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     reg_wr,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [DATA_W-1:0]        reg_wdata,
  input logic [NUM_CTR-1:0]       event_in,
  input logic                     irq,
  input logic [NUM_CTR-1:0]       ovf_q,
  input logic [NUM_CTR-1:0]       wrap_vec,
  input logic [NUM_CTR-1:0]       pmi_vec,
  input logic [NUM_CTR-1:0]       ld_vec,
  input logic [NUM_CTR*CTR_W-1:0] cnt_flat
);

  logic clr_wr;
  assign clr_wr = reg_wr && reg_addr == ADDR_W'(A_CLR);

  p_rst_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ovf_q == '0 && !irq));

  p_irq_single_r9: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (rst)
    (|(wrap_vec & pmi_vec)) |=> irq);

  p_irq_none_r9: assert property (@(posedge clk) disable iff (rst)
    !(|(wrap_vec & pmi_vec)) |=> !irq);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_p
    p_wrap_sets_r7: assert property (@(posedge clk) disable iff (rst)
      wrap_vec[i] |=> ovf_q[i]);

    p_wrap_zero_r7: assert property (@(posedge clk) disable iff (rst)
      wrap_vec[i] |=> cnt_flat[i*CTR_W +: CTR_W] == '0);

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      (ovf_q[i] && !(clr_wr && reg_wdata[i])) |=> ovf_q[i]);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!ld_vec[i] && !event_in[i]) |=> $stable(cnt_flat[i*CTR_W +: CTR_W]));
  end

endmodule

bind fxc_unit fxc_unit_chk #(
  .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .event_in  (event_in),
  .irq       (irq),
  .ovf_q     (ovf_q),
  .wrap_vec  (wrap_vec),
  .pmi_vec   (pmi_vec),
  .ld_vec    (ld_vec),
  .cnt_flat  (cnt_flat)
);

// File: tb/tb_fxc_unit.sv
module tb_fxc_unit;

  localparam int CLK_P = 10;
  localparam logic [63:0] CNT_MASK = 64'h0000_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [2:0]  event_in = '0;
  logic        priv_kernel = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;

  // Reference state
  logic [63:0] m_cnt [3];
  logic [11:0] m_ctl;
  logic [2:0]  m_gen;
  logic [2:0]  m_ovf;

  always #(CLK_P/2) clk = ~clk;

  fxc_unit dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_in(event_in),
    .priv_kernel(priv_kernel), .irq(irq)
  );

  function automatic logic [63:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return (64'd48 << 5) | 64'd3;
      3'd1: return {52'd0, m_ctl};
      3'd2: return {61'd0, m_gen};
      3'd3: return {61'd0, m_ovf};
      3'd5: return m_cnt[0];
      3'd6: return m_cnt[1];
      3'd7: return m_cnt[2];
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: drive inputs, advance the model, compare after the edge
  task automatic step(input logic w, input logic [2:0] a, input logic [63:0] d,
                      input logic [2:0] ev, input logic pk, input string tag);
    logic [63:0] exp_rd;
    logic        exp_irq;
    logic [2:0]  wraps;
    reg_wr = w; reg_addr = a; reg_wdata = d; event_in = ev; priv_kernel = pk;
    exp_rd = m_read(a);
    wraps = '0;
    exp_irq = 1'b0;
    for (int i = 0; i < 3; i++) begin
      int code;
      bit ok;
      code = int'(m_ctl[4*i +: 2]);
      ok = (code == 3) || (code == 1 && pk) || (code == 2 && !pk);
      if (w && a == 3'(5 + i)) begin
        m_cnt[i] = d & CNT_MASK;
      end else if (ev[i] && m_gen[i] && ok) begin
        if (m_cnt[i] == CNT_MASK) begin
          wraps[i] = 1'b1;
          if (m_ctl[4*i+3]) exp_irq = 1'b1;
          m_cnt[i] = 64'd0;
        end else begin
          m_cnt[i] = m_cnt[i] + 64'd1;
        end
      end
    end
    if (w && a == 3'd4) m_ovf = m_ovf & ~d[2:0];
    m_ovf = m_ovf | wraps;
    if (w && a == 3'd1) m_ctl = d[11:0] & 12'hBBB;
    if (w && a == 3'd2) m_gen = d[2:0];
    @(negedge clk);
    check({tag, " rdata"}, reg_rdata, exp_rd);
    check({tag, " irq"}, {63'd0, irq}, {63'd0, exp_irq});
  endtask

  task automatic rd(input logic [2:0] a, input logic [2:0] ev, input logic pk, input string tag);
    step(1'b0, a, 64'd0, ev, pk, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d, input string tag);
    step(1'b1, a, d, 3'b000, 1'b0, tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) m_cnt[i] = '0;
    m_ctl = '0; m_gen = '0; m_ovf = '0;
    repeat (3) @(negedge clk);
    // R1: state during and right after reset
    check("R1 rdata in reset", reg_rdata, 64'd0);
    check("R1 irq in reset", {63'd0, irq}, 64'd0);
    rst = 1'b0;
    rd(3'd1, 3'b111, 1'b1, "R1 ctl");
    rd(3'd2, 3'b111, 1'b1, "R1 gen");
    rd(3'd3, 3'b111, 1'b1, "R1 stat");
    rd(3'd5, 3'b111, 1'b1, "R1 cnt0");

    // R10: capability word, write ignored
    rd(3'd0, 3'b000, 1'b0, "R10 cap");
    wr(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R10 cap write");
    rd(3'd0, 3'b000, 1'b0, "R10 cap after write");

    // R2: reserved control bits
    wr(3'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R2 ctl write ones");
    rd(3'd1, 3'b000, 1'b0, "R2 ctl masked");

    // R3: ring codes 1,2,3 on counters 0,1,2 at both levels
    wr(3'd1, 64'h321, "R3 ctl codes");
    wr(3'd2, 64'h7, "R4 enable all");
    for (int k = 0; k < 6; k++) rd(3'd5, 3'b111, 1'(k % 2), "R3 run");
    rd(3'd5, 3'b000, 1'b0, "R3 cnt0 kernel only");
    rd(3'd6, 3'b000, 1'b0, "R3 cnt1 user only");
    rd(3'd7, 3'b000, 1'b0, "R3 cnt2 any level");
    wr(3'd1, 64'h320, "R3 code0 on ctr0");
    for (int k = 0; k < 3; k++) rd(3'd5, 3'b111, 1'b1, "R3 code0 frozen");

    // R4: global enable gates counter 1
    wr(3'd1, 64'h333, "R4 all any");
    wr(3'd2, 64'h5, "R4 mask 101");
    for (int k = 0; k < 4; k++) rd(3'd6, 3'b111, 1'b0, "R4 ctr1 gated");
    rd(3'd7, 3'b000, 1'b0, "R4 ctr2 counted");
    wr(3'd2, 64'h7, "R4 mask 111");

    // R5: sparse event patterns
    rd(3'd5, 3'b001, 1'b0, "R5 ev 001");
    rd(3'd6, 3'b010, 1'b1, "R5 ev 010");
    rd(3'd7, 3'b100, 1'b0, "R5 ev 100");
    rd(3'd5, 3'b000, 1'b1, "R5 ev none");
    rd(3'd6, 3'b110, 1'b0, "R5 ev 110");
    rd(3'd7, 3'b000, 1'b0, "R5 cnt2");

    // R6: load masks upper bits, load beats increment
    step(1'b1, 3'd5, 64'hFFFF_1234_5678_9ABC, 3'b001, 1'b0, "R6 load with event");
    rd(3'd5, 3'b000, 1'b0, "R6 cnt0 loaded");

    // R7 / R9: wrap with interrupt enabled on counter 0
    wr(3'd1, 64'h33B, "R9 pmi ctr0");
    wr(3'd5, 64'hFFFF_FFFF_FFFF_FFFF, "R7 load ones");
    rd(3'd3, 3'b001, 1'b0, "R7 wrap edge");
    rd(3'd3, 3'b000, 1'b0, "R9 after pulse");
    rd(3'd5, 3'b000, 1'b0, "R7 cnt0 zero");
    rd(3'd3, 3'b000, 1'b0, "R7 sticky");

    // R9: wrap on counter 1 without interrupt enable
    wr(3'd6, 64'h0000_FFFF_FFFF_FFFF, "R9 load ctr1");
    rd(3'd3, 3'b010, 1'b1, "R9 no irq wrap");
    rd(3'd3, 3'b000, 1'b0, "R7 stat 011");

    // R8: write-one-to-clear, reads zero, set wins
    wr(3'd4, 64'h1, "R8 clear bit0");
    rd(3'd3, 3'b000, 1'b0, "R8 stat after clear");
    rd(3'd4, 3'b000, 1'b0, "R8 clr reads zero");
    wr(3'd4, 64'h0, "R8 zero write");
    rd(3'd3, 3'b000, 1'b0, "R8 zero write no effect");
    wr(3'd7, 64'h0000_FFFF_FFFF_FFFF, "R8 load ctr2");
    step(1'b1, 3'd4, 64'h4, 3'b100, 1'b1, "R8 wrap and clear");
    rd(3'd3, 3'b000, 1'b0, "R8 set wins");
    wr(3'd4, 64'h7, "R8 clear all");
    rd(3'd3, 3'b000, 1'b0, "R8 all clear");

    // R11: read while counting shows pre-edge value
    for (int k = 0; k < 4; k++) rd(3'd7, 3'b100, 1'b0, "R11 read during count");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule